// File: doc/BRIEF.md
# I2C Power-Control Register Slave

This block is a two-wire serial slave that owns a single 8-bit control register for a power-supply controller. A host writes six control bits: enable, voltage select, line-loss compensation, tone enable, transmit-path select and pulsed current-limit mode. A read returns those six bits together with two live fault flags from other blocks: overload and over-temperature.

SCL and SDA are sampled by a fast system clock through a synchronizer, and bus events are detected from the synchronized levels. The slave drives SDA only through an open-drain enable. Its 7-bit address is a fixed 5-bit base with two low bits taken from a strap input. While the undervoltage input is high, the slave neither acknowledges nor accepts writes.

Top module: `pwr_ctl_i2c_slave`

## Requirements
- R1: After reset, all six control outputs are 0, which places the supply in standby, and `sda_oe_o` is 0.
- R2: The slave responds only to address 7'b00010 followed by `addr_sel_i[1:0]`. Any other address gets no acknowledge, and the bytes that follow it up to the next START leave the register unchanged.
- R3: When the address matches, the slave pulls SDA low for the whole ninth clock after the address byte and after each written data byte.
- R4: A written data byte (MSB first) loads its bits [5:0] into en[0], vsel[1], llc[2], ten[3], ttx[4], pcl[5]. Bits [7:6] of the byte are ignored.
- R5: A read returns the byte {otf_i, olf_i, pcl, ttx, ten, llc, vsel, en}, MSB first. The slave sends another byte each time the master acknowledges, and stops driving after a master no-acknowledge.
- R6: While `uvlo_i` is 1, the slave never drives an acknowledge and does not update the register.
- R7: A START that arrives in the middle of a byte drops the partial byte and restarts address reception.
- R8: After a STOP, SDA is released. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Strap for the low two address bits |
| uvlo_i | input | 1 | Undervoltage lockout, blocks acknowledge and writes |
| olf_i | input | 1 | Overload flag, read-only bit 6 |
| otf_i | input | 1 | Over-temperature flag, read-only bit 7 |
| en_o | output | 1 | Supply enable |
| vsel_o | output | 1 | Output voltage select |
| llc_o | output | 1 | Line-loss compensation boost |
| ten_o | output | 1 | Continuous tone enable |
| ttx_o | output | 1 | Transmit-path select |
| pcl_o | output | 1 | Static (1) or pulsed (0) current limiting |

## Verification
Each SCL or SDA edge reaches the control logic three system clocks after the pin changes: two synchronizer flops and one state register. The acknowledge, read-bit drive and register update all appear three cycles after the SCL edge that causes them. The bench holds every bus phase for 16 system clocks. It samples SDA halfway through the SCL high phase and reads the control outputs only after the acknowledge clock has ended, so every sample lies well beyond that three-cycle window.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WR, ST_ACK, ST_RD, ST_RACK
  } slv_state_e;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned CTRL_W = 6;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA edges count as bus conditions only while SCL stays high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;

  AST_EVENT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o})); // R7
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic             uvlo_i,
  input  logic [REG_W-1:0] rd_byte_i,
  output logic             wr_stb_o,
  output logic [REG_W-1:0] wr_data_o,
  output logic             sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(REG_W);

  slv_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] sh_q, tx_q, byte_in;
  logic             rd_mode_q, ack_on_q, oe_q;
  logic             last_bit;

  assign byte_in  = {sh_q[REG_W-2:0], sda_i};
  assign last_bit = (cnt_q == CNT_W'(REG_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rd_mode_q <= 1'b0;
      ack_on_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      ack_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      ack_on_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise_i) begin
          sh_q  <= byte_in;
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) begin
            if (byte_in[REG_W-1:1] == dev_addr_i && !uvlo_i) begin
              state_q   <= ST_ACK;
              rd_mode_q <= byte_in[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WR: if (scl_rise_i) begin
          sh_q  <= byte_in;
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) state_q <= uvlo_i ? ST_IDLE : ST_ACK;
        end
        ST_ACK: if (scl_fall_i) begin
          if (!ack_on_q) begin
            if (uvlo_i) state_q <= ST_IDLE;
            else begin
              ack_on_q <= 1'b1;
              oe_q     <= 1'b1;
            end
          end else begin
            ack_on_q <= 1'b0;
            cnt_q    <= '0;
            if (rd_mode_q) begin
              state_q <= ST_RD;
              tx_q    <= rd_byte_i;
              oe_q    <= ~rd_byte_i[REG_W-1];
            end else begin
              state_q <= ST_WR;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) state_q <= ST_RACK;
            else          tx_q    <= tx_q << 1;
          end else if (scl_fall_i) begin
            oe_q <= ~tx_q[REG_W-1];
          end
        end
        ST_RACK: begin
          if (scl_fall_i) oe_q <= 1'b0;
          else if (scl_rise_i) begin
            if (!sda_i) begin
              state_q <= ST_RD;
              tx_q    <= rd_byte_i;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_stb_o  = (state_q == ST_WR) && scl_rise_i && last_bit && !uvlo_i
                     && !start_i && !stop_i;
  assign wr_data_o = byte_in;
  assign sda_oe_o  = oe_q;

  AST_UVLO_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(uvlo_i) |-> !$rose(ack_on_q)); // R6
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R8
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i)); // R8
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              olf_i,
  input  logic              otf_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [REG_W-1:0]  rd_byte_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (wr_stb_i) ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  assign ctrl_o    = ctrl_q;
  assign rd_byte_o = {otf_i, olf_i, ctrl_q};

  AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(wr_stb_i)); // R4
endmodule

// File: rtl/pwr_ctl_i2c_slave.sv
module pwr_ctl_i2c_slave
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SEL_W       = 2,
  parameter logic [ADDR_W-SEL_W-1:0] ADDR_BASE = 5'b00010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [SEL_W-1:0] addr_sel_i,
  input  logic             uvlo_i,
  input  logic             olf_i,
  input  logic             otf_i,
  output logic             en_o,
  output logic             vsel_o,
  output logic             llc_o,
  output logic             ten_o,
  output logic             ttx_o,
  output logic             pcl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic wr_stb;
  logic [REG_W-1:0]  wr_data, rd_byte;
  logic [CTRL_W-1:0] ctrl;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop),
    .dev_addr_i({ADDR_BASE, addr_sel_i}), .uvlo_i, .rd_byte_i(rd_byte),
    .wr_stb_o(wr_stb), .wr_data_o(wr_data), .sda_oe_o
  );

  pwr_ctl_reg u_reg (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .olf_i, .otf_i, .ctrl_o(ctrl), .rd_byte_o(rd_byte)
  );

  assign {pcl_o, ttx_o, ten_o, llc_o, vsel_o, en_o} = ctrl;
endmodule

// File: tb/sim_pwr_ctl_i2c_slave.sv
module sim_pwr_ctl_i2c_slave;
  localparam int Q = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic uvlo = 1'b0, olf = 1'b0, otf = 1'b0;
  logic sda_oe, sda_line;
  logic en, vsel, llc, ten, ttx, pcl;
  int n_vec = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  pwr_ctl_i2c_slave u0 (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .uvlo_i(uvlo), .olf_i(olf), .otf_i(otf),
    .en_o(en), .vsel_o(vsel), .llc_o(llc), .ten_o(ten), .ttx_o(ttx), .pcl_o(pcl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ctrl_now();
    return {pcl, ttx, ten, llc, vsel, en};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q); scl = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q); scl = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q); scl = 1'b1; wait_n(Q); sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_n(Q); scl = 1'b1; wait_n(Q); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wait_n(Q); scl = 1'b1; wait_n(Q/2);
    ack = ~sda_line; wait_n(Q/2); scl = 1'b0;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(Q); scl = 1'b1; wait_n(Q/2); d[i] = sda_line; wait_n(Q/2); scl = 1'b0;
    end
    sda_m = ~mack; wait_n(Q); scl = 1'b1; wait_n(Q); scl = 1'b0; sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [6:0] a, input logic [7:0] d,
                           output logic ack_a, output logic ack_d);
    bus_start(); send_byte({a, 1'b0}, ack_a); send_byte(d, ack_d); bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 ctrl after reset", ctrl_now(), 6'h00);
    chk("R1 sda released after reset", sda_oe, 1'b0);
  endtask

  task automatic t_write();
    logic aa, ad;
    write_reg(7'h09, 8'hFF, aa, ad);
    chk("R3 address ack", aa, 1'b1);
    chk("R3 data ack", ad, 1'b1);
    chk("R4 write ff drops bits 7:6", ctrl_now(), 6'h3F);
    chk("R8 released after stop", sda_oe, 1'b0);
    write_reg(7'h09, 8'hC5, aa, ad);
    chk("R4 write c5", ctrl_now(), 6'h05);
  endtask

  task automatic t_read();
    logic a; logic [7:0] d0, d1;
    olf = 1'b1; otf = 1'b0;
    bus_start(); send_byte({7'h09, 1'b1}, a);
    read_byte(1'b1, d0); read_byte(1'b0, d1); bus_stop();
    chk("R3 read address ack", a, 1'b1);
    chk("R5 read byte 0", d0, 8'h45);
    chk("R5 read byte 1 after master ack", d1, 8'h45);
    chk("R8 released after no-ack", sda_oe, 1'b0);
    olf = 1'b0; otf = 1'b1;
    bus_start(); send_byte({7'h09, 1'b1}, a); read_byte(1'b0, d0); bus_stop();
    chk("R5 read with otf", d0, 8'h85);
    otf = 1'b0;
  endtask

  task automatic t_wrong_addr();
    logic aa, ad;
    write_reg(7'h0A, 8'h3A, aa, ad);
    chk("R2 foreign address no ack", aa, 1'b0);
    chk("R2 data after foreign address no ack", ad, 1'b0);
    chk("R2 register unchanged", ctrl_now(), 6'h05);
  endtask

  task automatic t_addr_sel();
    logic aa, ad;
    addr_sel = 2'b11;
    write_reg(7'h0B, 8'h2A, aa, ad);
    chk("R2 strap 11 ack", aa, 1'b1);
    chk("R2 strap 11 write", ctrl_now(), 6'h2A);
    write_reg(7'h09, 8'h00, aa, ad);
    chk("R2 old address no ack", aa, 1'b0);
    chk("R2 old address no write", ctrl_now(), 6'h2A);
    addr_sel = 2'b01;
  endtask

  task automatic t_uvlo();
    logic aa, ad;
    uvlo = 1'b1;
    write_reg(7'h09, 8'h11, aa, ad);
    chk("R6 no address ack in uvlo", aa, 1'b0);
    chk("R6 no data ack in uvlo", ad, 1'b0);
    chk("R6 no write in uvlo", ctrl_now(), 6'h2A);
    uvlo = 1'b0;
  endtask

  task automatic t_restart();
    logic aa, ad;
    bus_start(); send_bits(8'hFF, 3);
    bus_start(); send_byte({7'h09, 1'b0}, aa); send_byte(8'h15, ad);
    chk("R7 ack after mid-byte start", aa, 1'b1);
    send_bits(8'hA0, 5);
    bus_start(); send_byte({7'h09, 1'b0}, aa); send_byte(8'h33, ad); bus_stop();
    chk("R7 data after restart", ad, 1'b1);
    chk("R7 register after restarts", ctrl_now(), 6'h33);
  endtask

  initial begin
    wait_n(5); rst_ni = 1'b1; wait_n(5);
    t_reset();
    t_write();
    t_read();
    t_wrong_addr();
    t_addr_sel();
    t_uvlo();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule